// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is an 18-bit first-in first-out buffer that links two unrelated clock domains. The producer writes on its own clock and the consumer reads on its own clock. Both enables are active low. The depth is a parameter, from 256 to 4096 words, and the default is 256.

Besides the full and empty indications, the buffer drives three level flags: half-full, almost-full and almost-empty. The two almost thresholds are held in a pair of offset registers. While the load strobe is low, a write-side strobe stores the low twelve bits of the data input into these registers instead of the memory. A read-side strobe in the same state places a register's contents on the data output. A static mode input selects one of two read modes. In standard mode a read strobe fetches the next word. In look-ahead (first-word-fall-through) mode the head word is already presented, and the empty output then means that valid data is present.

Pointers cross between the domains in Gray code. Each domain therefore sees the other side's position a few cycles late. Because of this, full and empty may stay set a little longer than strictly needed, but they never clear too early.

Top module: `dual_clock_fifo`

## Requirements
- R1: While `rst` is high and after it is released, the pointers are at location 0. `space_ok`, `half_n` and `almost_full_n` are 1, and `data_ok` and `almost_empty_n` are 0.
- R2: A word is stored on a rising `wclk` edge when `wr_en_n`=0, `ld_n`=1 and `space_ok`=1. After DEPTH stored words with no reads, `space_ok` is 0 and further writes are dropped.
- R3: In standard mode (`fwft`=0), a rising `rclk` edge with `rd_en_n`=0, `ld_n`=1 and `data_ok`=1 puts the oldest word on `dout`. Words come out in write order. With `rd_en_n`=1, or with `data_ok`=0, `dout` keeps its value.
- R4: A rising `wclk` edge with `ld_n`=0 and `wr_en_n`=0 stores `din[11:0]` into an offset register and leaves the memory and the write pointer unchanged. Successive loads alternate between registers: the almost-empty offset first, then the almost-full offset.
- R5: A rising `rclk` edge with `ld_n`=0 and `rd_en_n`=0 puts an offset on `dout[11:0]`, with `dout[17:12]`=0. Successive readbacks alternate in the same order as loads, almost-empty first. The two sides keep separate alternation state, and reset clears both.
- R6: After reset both offsets equal 31 for DEPTH 256, 63 for DEPTH 512, and 127 for larger depths.
- R7: `half_n` is 0 exactly when the stored word count exceeds DEPTH/2.
- R8: `almost_empty_n` is 0 exactly when the stored word count is at or below the almost-empty offset.
- R9: `almost_full_n` is 0 exactly when DEPTH minus the stored word count is at or below the almost-full offset.
- R10: In look-ahead mode (`fwft`=1), the first written word appears on `dout` without a read strobe, and `data_ok` rises with it. A strobe with `rd_en_n`=0 and `ld_n`=1 consumes the presented word.
- R11: While `oe_n` is 1, `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Active-high reset, sampled synchronously by both clocks |
| fwft | input | 1 | Static read mode: 0 standard, 1 look-ahead |
| wr_en_n | input | 1 | Active-low write strobe |
| din | input | 18 | Write data; bits 11:0 carry offset values during loads |
| rd_en_n | input | 1 | Active-low read strobe |
| ld_n | input | 1 | Active-low offset-register access select |
| oe_n | input | 1 | Active-low output gate |
| dout | output | 18 | Read data, or an offset during readback |
| space_ok | output | 1 | 1 when a write would be accepted (low means full) |
| data_ok | output | 1 | Standard mode: 1 when not empty; look-ahead mode: 1 when `dout` is valid |
| half_n | output | 1 | Low when more than half full |
| almost_full_n | output | 1 | Low when free space is at or below the almost-full offset |
| almost_empty_n | output | 1 | Low when held words are at or below the almost-empty offset |

## Verification
The hardest conditions to reach are the flag thresholds. Each flag edge depends on a word count that is only visible a few cycles later on the opposite clock. The stimulus reaches each edge directly: it fills the buffer to the point where writes are refused, then drains it one word at a time. After every step it lets both synchronisers settle before sampling, so the exact boundary of each flag is checked with the programmed offsets of 10 and 20. Random phases then stress the reordering and drop cases, with both sides active on unrelated clocks.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int OFF_W = 12;
  typedef logic [OFF_W-1:0] off_t;

  function automatic int dflt_offset(input int depth);
    if (depth <= 256) return 31;
    else if (depth <= 512) return 63;
    else return 127;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk)
    if (we) mem[waddr] <= wdata;

  always_ff @(posedge rclk)
    if (re) rdata <= mem[raddr];
endmodule

// File: rtl/dcf_offsets.sv
module dcf_offsets
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic wclk,
  input  logic rclk,
  input  logic rst,
  input  logic wr_ld,
  input  off_t wdata,
  input  logic rd_ld,
  output off_t ae_off,
  output off_t af_off,
  output off_t rd_word
);
  localparam off_t DFLT = off_t'(dflt_offset(DEPTH));

  logic wsel, rsel;

  always_ff @(posedge wclk) begin
    if (rst) begin
      ae_off <= DFLT;
      af_off <= DFLT;
      wsel   <= 1'b0;
    end else if (wr_ld) begin
      if (wsel) af_off <= wdata;
      else      ae_off <= wdata;
      wsel <= ~wsel;
    end
  end

  always_ff @(posedge rclk) begin
    if (rst) begin
      rd_word <= '0;
      rsel    <= 1'b0;
    end else if (rd_ld) begin
      rd_word <= rsel ? af_off : ae_off;
      rsel    <= ~rsel;
    end
  end

  p_ae_first_r4: assert property (@(posedge wclk) disable iff (rst)
    (wr_ld && !wsel) |=> (ae_off == $past(wdata)));
  p_af_second_r4: assert property (@(posedge wclk) disable iff (rst)
    (wr_ld && wsel) |=> (af_off == $past(wdata)));
  p_rb_order_r5: assert property (@(posedge rclk) disable iff (rst)
    rd_ld |=> (rsel != $past(rsel)));
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 18
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          fwft,
  input  logic          wr_en_n,
  input  logic [DW-1:0] din,
  input  logic          rd_en_n,
  input  logic          ld_n,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          space_ok,
  output logic          data_ok,
  output logic          half_n,
  output logic          almost_full_n,
  output logic          almost_empty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  off_t ae_off, af_off, cfg_word;
  logic [DW-1:0] ram_q, core_q;

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin, wgray, rgray_w, rbin_w;
  logic [PW-1:0] wbin_nx, wcnt_nx, wfree_nx;
  logic full_q, afull_q, half_q, wr_do, wr_ld;

  assign wr_do    = !wr_en_n && ld_n && !full_q;
  assign wr_ld    = !wr_en_n && !ld_n;
  assign rbin_w   = g2b(rgray_w);
  assign wbin_nx  = wbin + PW'(wr_do);
  assign wcnt_nx  = wbin_nx - rbin_w;
  assign wfree_nx = PW'(DEPTH) - wcnt_nx;

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin    <= '0;
      wgray   <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= b2g(wbin_nx);
      full_q  <= (wcnt_nx == PW'(DEPTH));
      afull_q <= (32'(wfree_nx) <= 32'(af_off));
      half_q  <= (32'(wcnt_nx) > (DEPTH / 2));
    end
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rbin, rgray, wgray_r, wbin_r;
  logic [PW-1:0] rbin_nx, rcnt_nx;
  logic [31:0]   held_nx;
  logic empty_q, aempty_q, ovalid, ovalid_nx, show_cfg;
  logic consume, rd_ld, mem_rd;

  assign consume   = !rd_en_n && ld_n;
  assign rd_ld     = !rd_en_n && !ld_n;
  assign wbin_r    = g2b(wgray_r);
  assign mem_rd    = !empty_q && (fwft ? (!ovalid || consume) : consume);
  assign rbin_nx   = rbin + PW'(mem_rd);
  assign rcnt_nx   = wbin_r - rbin_nx;
  assign ovalid_nx = fwft && (mem_rd || (ovalid && !consume));
  assign held_nx   = 32'(rcnt_nx) + 32'(ovalid_nx);

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin     <= '0;
      rgray    <= '0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
      ovalid   <= 1'b0;
      show_cfg <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= b2g(rbin_nx);
      empty_q  <= (rcnt_nx == '0);
      aempty_q <= (held_nx <= 32'(ae_off));
      ovalid   <= ovalid_nx;
      if (mem_rd)     show_cfg <= 1'b0;
      else if (rd_ld) show_cfg <= 1'b1;
    end
  end

  // ---------------- sub-blocks ----------------
  dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_w));
  dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_r));

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(wr_do), .waddr(wbin[AW-1:0]), .wdata(din),
    .rclk(rclk), .re(mem_rd), .raddr(rbin[AW-1:0]), .rdata(ram_q)
  );

  dcf_offsets #(.DEPTH(DEPTH)) u_off (
    .wclk(wclk), .rclk(rclk), .rst(rst),
    .wr_ld(wr_ld), .wdata(din[OFF_W-1:0]),
    .rd_ld(rd_ld),
    .ae_off(ae_off), .af_off(af_off), .rd_word(cfg_word)
  );

  // ---------------- outputs ----------------
  assign core_q         = show_cfg ? {{(DW-OFF_W){1'b0}}, cfg_word} : ram_q;
  assign dout           = oe_n ? '0 : core_q;
  assign space_ok       = !full_q;
  assign data_ok        = fwft ? ovalid : !empty_q;
  assign half_n         = !half_q;
  assign almost_full_n  = !afull_q;
  assign almost_empty_n = !aempty_q;

  // ---------------- assertions ----------------
  p_no_overflow_r2: assert property (@(posedge wclk) disable iff (rst)
    (full_q && !wr_en_n) |=> $stable(wbin));
  p_wgray_step_r2: assert property (@(posedge wclk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
  p_ld_no_push_r4: assert property (@(posedge wclk) disable iff (rst)
    (!ld_n && !wr_en_n) |=> $stable(wbin));
  p_full_is_half_r7: assert property (@(posedge wclk) disable iff (rst)
    full_q |-> half_q);
  p_no_underflow_r3: assert property (@(posedge rclk) disable iff (rst)
    (!fwft && empty_q && !rd_en_n) |=> $stable(rbin));
  p_hold_r3: assert property (@(posedge rclk) disable iff (rst)
    (!fwft && rd_en_n) |=> $stable(core_q));
  p_ready_holds_r10: assert property (@(posedge rclk) disable iff (rst)
    (fwft && ovalid && rd_en_n) |=> ovalid);
  p_oe_gate_r11: assert property (@(posedge rclk) disable iff (rst)
    oe_n |-> (dout == '0));
endmodule

// File: tb/dual_clock_fifo_tb.sv
module dual_clock_fifo_tb;
  localparam int DEPTH = 256;
  localparam int DW    = 18;

  logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1, fwft = 1'b0;
  logic wr_en_n = 1'b1, rd_en_n = 1'b1, ld_n = 1'b1, oe_n = 1'b0;
  logic [DW-1:0] din = '0, dout;
  logic space_ok, data_ok, half_n, almost_full_n, almost_empty_n;

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] model[$];

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dual_clock_fifo #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst(rst), .fwft(fwft),
    .wr_en_n(wr_en_n), .din(din), .rd_en_n(rd_en_n), .ld_n(ld_n), .oe_n(oe_n),
    .dout(dout), .space_ok(space_ok), .data_ok(data_ok), .half_n(half_n),
    .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n)
  );

  function automatic logic exp_half(int cnt);       return !(cnt > DEPTH / 2); endfunction
  function automatic logic exp_aempty(int cnt, int off); return !(cnt <= off); endfunction
  function automatic logic exp_afull(int cnt, int off);  return !((DEPTH - cnt) <= off); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic do_reset(logic mode);
    rst = 1'b1; fwft = mode; wr_en_n = 1'b1; rd_en_n = 1'b1; ld_n = 1'b1;
    model.delete();
    repeat (10) @(negedge rclk);
    rst = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
    @(negedge rclk);
  endtask

  task automatic push(logic [DW-1:0] d);
    logic ok;
    @(negedge wclk);
    ok = space_ok; din = d; wr_en_n = 1'b0;
    @(negedge wclk);
    wr_en_n = 1'b1;
    if (ok) model.push_back(d);
  endtask

  task automatic pop_check(string req);
    logic avail;
    logic [DW-1:0] exp;
    @(negedge rclk);
    avail = data_ok; rd_en_n = 1'b0;
    @(negedge rclk);
    rd_en_n = 1'b1;
    if (avail) begin
      exp = model.pop_front();
      chk(req, 32'(dout), 32'(exp));
    end
  endtask

  task automatic prog(logic [11:0] v);
    @(negedge wclk);
    ld_n = 1'b0; wr_en_n = 1'b0; din = {6'h2A, v};
    @(negedge wclk);
    wr_en_n = 1'b1; ld_n = 1'b1;
  endtask

  task automatic readback(string req, int exp);
    @(negedge rclk);
    ld_n = 1'b0; rd_en_n = 1'b0;
    @(negedge rclk);
    rd_en_n = 1'b1; ld_n = 1'b1;
    chk(req, 32'(dout), 32'(exp));
  endtask

  task automatic flags(string req, int ae, int af);
    int cnt = model.size();
    chk({req, " half"},   32'(half_n),         32'(exp_half(cnt)));
    chk({req, " aempty"}, 32'(almost_empty_n), 32'(exp_aempty(cnt, ae)));
    chk({req, " afull"},  32'(almost_full_n),  32'(exp_afull(cnt, af)));
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    logic [DW-1:0] last;
    void'($urandom(32'd1234));

    // R1 reset state
    do_reset(1'b0);
    settle();
    chk("R1 space_ok", 32'(space_ok), 1);
    chk("R1 data_ok", 32'(data_ok), 0);
    chk("R1 half_n", 32'(half_n), 1);
    chk("R1 almost_full_n", 32'(almost_full_n), 1);
    chk("R1 almost_empty_n", 32'(almost_empty_n), 0);

    // R6 defaults, R5 readback order
    readback("R6 default ae", 31);
    readback("R6 default af", 31);

    // R11 output gate
    oe_n = 1'b1; #1;
    chk("R11 gated dout", 32'(dout), 0);
    oe_n = 1'b0; #1;
    chk("R11 ungated dout", 32'(dout), 31);

    // R4 program offsets with data already stored
    for (int i = 0; i < 5; i++) push(DW'($urandom));
    prog(12'd10);
    prog(12'd20);
    settle();
    chk("R3 not empty", 32'(data_ok), 1);
    flags("R8 five words", 10, 20);
    readback("R5 ae readback", 10);
    readback("R5 af readback", 20);

    for (int i = 0; i < 6; i++) push(DW'($urandom));
    settle();
    flags("R8 eleven words", 10, 20);

    // R2 fill past capacity
    for (int i = 0; i < 300; i++) push(DW'($urandom));
    chk("R2 stored count", 32'(model.size()), DEPTH);
    settle();
    chk("R2 full", 32'(space_ok), 0);
    flags("R9 full", 10, 20);

    // R9 almost-full boundary
    for (int i = 0; i < 20; i++) pop_check("R3 order");
    settle();
    flags("R9 free 20", 10, 20);
    pop_check("R3 order");
    settle();
    flags("R9 free 21", 10, 20);
    chk("R2 space again", 32'(space_ok), 1);

    // R7 half boundary
    while (model.size() > DEPTH / 2 + 1) pop_check("R3 order");
    settle();
    flags("R7 half+1", 10, 20);
    pop_check("R3 order");
    settle();
    flags("R7 half", 10, 20);

    // R8 almost-empty boundary
    while (model.size() > 11) pop_check("R3 order");
    settle();
    flags("R8 eleven", 10, 20);
    pop_check("R3 order");
    settle();
    flags("R8 ten", 10, 20);

    // R3 drain, then read on empty is ignored
    while (model.size() > 0) pop_check("R3 order");
    settle();
    chk("R3 empty", 32'(data_ok), 0);
    last = dout;
    @(negedge rclk); rd_en_n = 1'b0;
    @(negedge rclk); rd_en_n = 1'b1;
    @(negedge rclk);
    chk("R3 empty read holds", 32'(dout), 32'(last));

    // R2/R3 random concurrent traffic
    fork
      begin
        for (int i = 0; i < 3000; i++) begin
          @(negedge wclk);
          din = DW'($urandom);
          wr_en_n = ($urandom % 3) == 0;
          if (!wr_en_n && space_ok) model.push_back(din);
        end
        @(negedge wclk); wr_en_n = 1'b1;
      end
      begin
        logic pend = 1'b0;
        for (int i = 0; i < 2000; i++) begin
          @(negedge rclk);
          if (pend) chk("R3 random order", 32'(dout), 32'(model.pop_front()));
          rd_en_n = ($urandom % 2) == 0;
          pend = !rd_en_n && data_ok;
        end
        @(negedge rclk);
        rd_en_n = 1'b1;
        if (pend) chk("R3 random order", 32'(dout), 32'(model.pop_front()));
      end
    join
    settle();
    while (model.size() > 0) pop_check("R2 random drain");

    // R10 look-ahead mode
    do_reset(1'b1);
    settle();
    chk("R10 not ready", 32'(data_ok), 0);
    push(18'h15A5A);
    settle();
    chk("R10 ready", 32'(data_ok), 1);
    chk("R10 first word falls", 32'(dout), 32'h15A5A);
    for (int i = 0; i < 3; i++) push(DW'($urandom));
    settle();
    for (int i = 0; i < 4; i++) begin
      @(negedge rclk);
      chk("R10 presented word", 32'(dout), 32'(model.pop_front()));
      rd_en_n = 1'b0;
      @(negedge rclk);
      rd_en_n = 1'b1;
    end
    settle();
    chk("R10 drained", 32'(data_ok), 0);

    summary();
  end
endmodule